// File: doc/BRIEF.md
# Machine-Mode Control and Status Register File

This unit holds the control and status registers of a 32-bit core that runs in machine mode only. The pipeline presents one CSR request per cycle: an operation (read, write, set bits, clear bits), a 12-bit address and a source operand. In the same cycle the unit returns the register's current value and an illegal flag. If the request is legal, the new value is stored at the next rising edge.

A second port, separate from the request port, carries the floating-point exception flags of up to `LANES` instructions that retire together. These flags are ORed into the sticky accrued-flag register. The unit also keeps the floating-point dirty state in the status register current, and derives the summary-dirty bit from it.

The registers held are:
- the status word: interrupt enable, previous enable, previous privilege fixed at machine, floating-point state, and summary-dirty;
- the exception return address;
- the trap vector, scratch, cause and trap value registers;
- the floating-point accrued flags and rounding mode, with their combined view;
- the read-only identification registers and the ISA description.

Top module: `csr_mfile`

## Requirements
- R1: The return-address register (0x341) always reads with bits 1:0 equal to zero. A write of 0x00000001 reads back as 0x00000000, and a write of 0xFFFFFFFF reads back as 0xFFFFFFFC.
- R2: A request of any kind to an address the unit does not implement, such as 0x394, raises `illegal` in that cycle and reads as zero. No register changes.
- R3: Addresses whose bits 11:10 are 2'b11 are read-only. A read, or a set or clear whose source is zero, returns the value with `illegal` low. A write, or a set or clear whose source is non-zero, raises `illegal` and changes nothing. Writes to the ISA register (0x301) are accepted and ignored.
- R4: Status word (0x300) layout:
  - bit 3: interrupt enable;
  - bit 7: previous interrupt enable;
  - bits 12:11: previous privilege, always reading 2'b11;
  - bits 14:13: floating-point state;
  - bit 31: reads 1 exactly when bits 14:13 are 2'b11.

  Setting 0x00007800 from reset reads back 0x80007800.
- R5: The accrued flags (0x001, 5 bits) are sticky. A commit ORs the flags of each valid lane into the stored value. A lane with zero flags leaves the set bits unchanged.
- R6: Flags of all valid lanes in one cycle are ORed together. The flags of lanes whose valid bit is low are ignored. Lane i uses `commit_flags[5*i+4:5*i]`.
- R7: When a CSR write to the flags and a commit happen in the same cycle, the stored value is the written value ORed with the committed flags.
- R8: The rounding mode (0x002) is 3 bits. The combined view (0x003) holds the rounding mode in bits 7:5 and the flags in bits 4:0. All three addresses are views of the same storage, and higher bits read as zero.
- R9: The floating-point state becomes 2'b11 after any legal write to 0x001, 0x002 or 0x003, and after any commit with non-zero flags on a valid lane. This holds even if the status word is written in the same cycle.
- R10: `rd_data` shows the value before the request. A write stores the operand, a set ORs it in, and a clear removes its set bits. Read-only fields keep their fixed values.
- R11: After reset the status word reads 0x00001800, and every writable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A CSR request is present |
| req_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| req_addr | input | 12 | CSR address |
| req_wdata | input | 32 | Source operand |
| rd_data | output | 32 | Value before the request |
| illegal | output | 1 | Request must trap as an illegal instruction |
| commit_valid | input | LANES | One bit per retiring lane |
| commit_flags | input | 5*LANES | Exception flags of each retiring lane |

## Verification
The request path is tried with plain writes, bit sets and bit clears on a scratch register. This separates the three update rules, and also shows that the returned value is the old one.

Unimplemented and read-only addresses are probed with reads, with zero-source sets and clears, and with real writes. This separates the trapping cases from the harmless ones, and the following reads confirm that state did not move.

The flag port is driven four ways:
- single lanes;
- a lane with zero flags;
- a lane with its valid bit low;
- both lanes at once.

It is then driven together with a CSR write to the flags, which separates sticky accumulation from overwriting and checks the order of the two updates. The status word is read after each floating-point update, so the dirty state and the summary bit are seen at the ports.

// File: rtl/csrf_pkg.sv
package csrf_pkg;
    typedef enum logic [1:0] {
        CSR_READ  = 2'd0,
        CSR_WRITE = 2'd1,
        CSR_SET   = 2'd2,
        CSR_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_FFLAGS, SEL_FRM, SEL_FCSR,
        SEL_MSTATUS, SEL_MISA, SEL_MTVEC, SEL_MSCRATCH,
        SEL_MEPC, SEL_MCAUSE, SEL_MTVAL,
        SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART
    } csr_sel_e;

    localparam int FLAG_W = 5;
    localparam int RM_W   = 3;
    localparam int ST_MIE  = 3;
    localparam int ST_MPIE = 7;
    localparam int ST_MPP  = 11;
    localparam int ST_FS   = 13;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csrf_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_e    sel,
    output logic        hit,
    output logic        ro
);
    always_comb begin
        unique case (addr)
            12'h001: sel = SEL_FFLAGS;
            12'h002: sel = SEL_FRM;
            12'h003: sel = SEL_FCSR;
            12'h300: sel = SEL_MSTATUS;
            12'h301: sel = SEL_MISA;
            12'h305: sel = SEL_MTVEC;
            12'h340: sel = SEL_MSCRATCH;
            12'h341: sel = SEL_MEPC;
            12'h342: sel = SEL_MCAUSE;
            12'h343: sel = SEL_MTVAL;
            12'hF11: sel = SEL_VENDOR;
            12'hF12: sel = SEL_ARCH;
            12'hF13: sel = SEL_IMPL;
            12'hF14: sel = SEL_HART;
            default: sel = SEL_NONE;
        endcase
        hit = (sel != SEL_NONE);
        ro  = (addr[11:10] == 2'b11);
    end
endmodule

// File: rtl/csr_fp_state.sv
module csr_fp_state
    import csrf_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_flags,
    input  logic                     wr_rm,
    input  logic [FLAG_W-1:0]        new_flags,
    input  logic [RM_W-1:0]          new_rm,
    input  logic [LANES-1:0]         commit_valid,
    input  logic [LANES*FLAG_W-1:0]  commit_flags,
    output logic [FLAG_W-1:0]        flags,
    output logic [RM_W-1:0]          rm,
    output logic                     dirty
);
    logic [FLAG_W-1:0] lane_acc [LANES+1];
    assign lane_acc[0] = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_acc[g+1] = lane_acc[g] |
            (commit_valid[g] ? commit_flags[g*FLAG_W +: FLAG_W] : '0);
    end

    logic [FLAG_W-1:0] base_flags;
    assign base_flags = wr_flags ? new_flags : flags;
    assign dirty      = wr_flags | wr_rm | (lane_acc[LANES] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            rm    <= '0;
        end else begin
            flags <= base_flags | lane_acc[LANES];
            if (wr_rm) rm <= new_rm;
        end
    end
endmodule

// File: rtl/csr_mregs.sv
module csr_mregs
    import csrf_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int EPC_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wen,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] wval,
    input  logic            fp_dirty,
    output logic [XLEN-1:0] mstatus,
    output logic [XLEN-1:0] mtvec,
    output logic [XLEN-1:0] mscratch,
    output logic [XLEN-1:0] mepc,
    output logic [XLEN-1:0] mcause,
    output logic [XLEN-1:0] mtval
);
    logic                    mie_q, mpie_q;
    logic [1:0]              fs_q;
    logic [XLEN-1:EPC_LSB]   epc_q;

    always_comb begin
        mstatus                  = '0;
        mstatus[ST_MIE]          = mie_q;
        mstatus[ST_MPIE]         = mpie_q;
        mstatus[ST_MPP +: 2]     = 2'b11;
        mstatus[ST_FS +: 2]      = fs_q;
        mstatus[XLEN-1]          = &fs_q;
        mepc                     = {epc_q, {EPC_LSB{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie_q    <= 1'b0;
            mpie_q   <= 1'b0;
            fs_q     <= 2'b00;
            epc_q    <= '0;
            mtvec    <= '0;
            mscratch <= '0;
            mcause   <= '0;
            mtval    <= '0;
        end else begin
            if (wen && sel == SEL_MSTATUS) begin
                mie_q  <= wval[ST_MIE];
                mpie_q <= wval[ST_MPIE];
            end
            if (fp_dirty)                      fs_q <= 2'b11;
            else if (wen && sel == SEL_MSTATUS) fs_q <= wval[ST_FS +: 2];
            if (wen && sel == SEL_MEPC)     epc_q    <= wval[XLEN-1:EPC_LSB];
            if (wen && sel == SEL_MTVEC)    mtvec    <= wval;
            if (wen && sel == SEL_MSCRATCH) mscratch <= wval;
            if (wen && sel == SEL_MCAUSE)   mcause   <= wval;
            if (wen && sel == SEL_MTVAL)    mtval    <= wval;
        end
    end
endmodule

// File: rtl/csr_mfile.sv
module csr_mfile
    import csrf_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          LANES        = 2,
    parameter bit          HALFWORD_ISA = 1'b0,
    parameter logic [31:0] ISA_WORD     = 32'h4000_1120,
    parameter logic [31:0] HART_NUM     = 32'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_op,
    input  logic [11:0]             req_addr,
    input  logic [XLEN-1:0]         req_wdata,
    output logic [XLEN-1:0]         rd_data,
    output logic                    illegal,
    input  logic [LANES-1:0]        commit_valid,
    input  logic [LANES*FLAG_W-1:0] commit_flags
);
    localparam int EPC_LSB = HALFWORD_ISA ? 1 : 2;

    csr_sel_e          sel;
    logic              hit, ro;
    logic              do_write, wen, flags_wr, rm_wr, fp_dirty;
    logic [XLEN-1:0]   wval;
    logic [FLAG_W-1:0] fflags;
    logic [RM_W-1:0]   frm;
    logic [XLEN-1:0]   mstatus, mtvec, mscratch, mepc, mcause, mtval;

    csr_decode u_dec (.addr(req_addr), .sel(sel), .hit(hit), .ro(ro));

    always_comb begin
        unique case (sel)
            SEL_FFLAGS:   rd_data = {{(XLEN-FLAG_W){1'b0}}, fflags};
            SEL_FRM:      rd_data = {{(XLEN-RM_W){1'b0}}, frm};
            SEL_FCSR:     rd_data = {{(XLEN-FLAG_W-RM_W){1'b0}}, frm, fflags};
            SEL_MSTATUS:  rd_data = mstatus;
            SEL_MISA:     rd_data = ISA_WORD;
            SEL_MTVEC:    rd_data = mtvec;
            SEL_MSCRATCH: rd_data = mscratch;
            SEL_MEPC:     rd_data = mepc;
            SEL_MCAUSE:   rd_data = mcause;
            SEL_MTVAL:    rd_data = mtval;
            SEL_HART:     rd_data = HART_NUM;
            default:      rd_data = '0;
        endcase
    end

    always_comb begin
        unique case (csr_op_e'(req_op))
            CSR_WRITE: wval = req_wdata;
            CSR_SET:   wval = rd_data | req_wdata;
            CSR_CLEAR: wval = rd_data & ~req_wdata;
            default:   wval = rd_data;
        endcase
        do_write = (csr_op_e'(req_op) == CSR_WRITE) ||
                   (csr_op_e'(req_op) != CSR_READ && req_wdata != '0);
        illegal  = req_valid && (!hit || (do_write && ro));
        wen      = req_valid && do_write && !illegal;
        flags_wr = wen && (sel == SEL_FFLAGS || sel == SEL_FCSR);
        rm_wr    = wen && (sel == SEL_FRM || sel == SEL_FCSR);
    end

    csr_fp_state #(.LANES(LANES)) u_fp (
        .clk(clk), .rst_n(rst_n),
        .wr_flags(flags_wr), .wr_rm(rm_wr),
        .new_flags(wval[FLAG_W-1:0]),
        .new_rm(sel == SEL_FCSR ? wval[FLAG_W +: RM_W] : wval[RM_W-1:0]),
        .commit_valid(commit_valid), .commit_flags(commit_flags),
        .flags(fflags), .rm(frm), .dirty(fp_dirty)
    );

    csr_mregs #(.XLEN(XLEN), .EPC_LSB(EPC_LSB)) u_mregs (
        .clk(clk), .rst_n(rst_n), .wen(wen), .sel(sel), .wval(wval),
        .fp_dirty(fp_dirty),
        .mstatus(mstatus), .mtvec(mtvec), .mscratch(mscratch),
        .mepc(mepc), .mcause(mcause), .mtval(mtval)
    );
endmodule

// File: rtl/csr_mfile_chk.sv
module csr_mfile_chk #(
    parameter int XLEN  = 32,
    parameter int LANES = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [1:0]             req_op,
    input logic [11:0]            req_addr,
    input logic [XLEN-1:0]        rd_data,
    input logic                   illegal,
    input logic [LANES-1:0]       commit_valid,
    input logic [LANES*5-1:0]     commit_flags,
    input logic [4:0]             fflags,
    input logic                   flags_wr,
    input logic [XLEN-1:0]        mepc,
    input logic [XLEN-1:0]        mstatus
);
    logic any_flag;
    always_comb begin
        any_flag = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (commit_valid[i] && commit_flags[i*5 +: 5] != 5'd0) any_flag = 1'b1;
    end

    // R1
    mepc_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h341) |-> rd_data[1:0] == 2'b00);

    // R2
    unimpl_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h394) |-> illegal);

    // R2
    trap_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && commit_valid == '0) |=> ($stable(mepc) && $stable(fflags) && $stable(mstatus)));

    // R3
    ro_write_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_addr[11:10] == 2'b11) |-> illegal);

    // R4
    sd_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h300) |-> rd_data[XLEN-1] == (rd_data[14:13] == 2'b11));

    // R5
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_wr |=> ((fflags & $past(fflags)) == $past(fflags)));

    // R9
    fs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |=> mstatus[14:13] == 2'b11);
endmodule

bind csr_mfile csr_mfile_chk #(.XLEN(XLEN), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .rd_data(rd_data), .illegal(illegal),
    .commit_valid(commit_valid), .commit_flags(commit_flags),
    .fflags(fflags), .flags_wr(flags_wr), .mepc(mepc), .mstatus(mstatus)
);

// File: tb/sim_csr_mfile.sv
module sim_csr_mfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_addr = 12'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] rd_data;
    logic        illegal;
    logic [1:0]  commit_valid = 2'b00;
    logic [9:0]  commit_flags = 10'h0;

    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3;

    always #10 clk = ~clk;

    csr_mfile u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .illegal(illegal), .commit_valid(commit_valid), .commit_flags(commit_flags)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic req(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] old, output logic ill);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        #2;
        old = rd_data; ill = illegal;
        @(posedge clk); #1;
        req_valid = 1'b0; req_op = OP_RD; req_wdata = '0;
    endtask

    task automatic rd_expect(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v; logic il;
        req(OP_RD, a, 32'h0, v, il);
        chk(tag, v, exp);
    endtask

    task automatic commit(input logic [1:0] v, input logic [9:0] f);
        @(negedge clk);
        commit_valid = v; commit_flags = f;
        @(posedge clk); #1;
        commit_valid = '0; commit_flags = '0;
    endtask

    task automatic t_reset;
        rd_expect("R11 mstatus", 12'h300, 32'h0000_1800);
        rd_expect("R11 mepc",    12'h341, 32'h0);
        rd_expect("R11 fcsr",    12'h003, 32'h0);
    endtask

    task automatic t_mepc;
        logic [31:0] v; logic il;
        req(OP_WR, 12'h341, 32'h1, v, il);
        rd_expect("R1 write 1", 12'h341, 32'h0);
        req(OP_WR, 12'h341, 32'hFFFF_FFFF, v, il);
        rd_expect("R1 write ones", 12'h341, 32'hFFFF_FFFC);
    endtask

    task automatic t_setclear;
        logic [31:0] v; logic il;
        req(OP_WR, 12'h340, 32'h0000_A5A5, v, il);
        req(OP_SET, 12'h340, 32'h0000_0F00, v, il);
        chk("R10 old value returned", v, 32'h0000_A5A5);
        rd_expect("R10 set", 12'h340, 32'h0000_AFA5);
        req(OP_CLR, 12'h340, 32'h0000_00A5, v, il);
        rd_expect("R10 clear", 12'h340, 32'h0000_AF00);
    endtask

    task automatic t_unimpl;
        logic [31:0] v; logic il;
        req(OP_WR, 12'h394, 32'h0000_FFFF, v, il);
        chk("R2 write unimpl traps", {31'h0, il}, 32'h1);
        req(OP_RD, 12'h394, 32'h0, v, il);
        chk("R2 read unimpl traps", {31'h0, il}, 32'h1);
        rd_expect("R2 scratch kept", 12'h340, 32'h0000_AF00);
        rd_expect("R2 status kept", 12'h300, 32'h0000_1800);
    endtask

    task automatic t_readonly;
        logic [31:0] v; logic il;
        req(OP_RD, 12'hF14, 32'h0, v, il);
        chk("R3 read ro no trap", {31'h0, il}, 32'h0);
        req(OP_WR, 12'hF14, 32'h0, v, il);
        chk("R3 write ro traps", {31'h0, il}, 32'h1);
        req(OP_SET, 12'hF11, 32'h0, v, il);
        chk("R3 zero set no trap", {31'h0, il}, 32'h0);
        req(OP_CLR, 12'hF12, 32'h1, v, il);
        chk("R3 nonzero clear traps", {31'h0, il}, 32'h1);
        req(OP_WR, 12'h301, 32'h0, v, il);
        chk("R3 isa write no trap", {31'h0, il}, 32'h0);
        rd_expect("R3 isa unchanged", 12'h301, 32'h4000_1120);
    endtask

    task automatic t_sd;
        logic [31:0] v; logic il;
        req(OP_SET, 12'h300, 32'h0000_7800, v, il);
        rd_expect("R4 set 7800", 12'h300, 32'h8000_7800);
        req(OP_CLR, 12'h300, 32'h0000_4000, v, il);
        rd_expect("R4 fs 01 no sd", 12'h300, 32'h0000_3800);
        req(OP_CLR, 12'h300, 32'h0000_6000, v, il);
        rd_expect("R4 fs off", 12'h300, 32'h0000_1800);
    endtask

    task automatic t_sticky;
        commit(2'b01, {5'h00, 5'h01});
        rd_expect("R5 first flag", 12'h001, 32'h01);
        rd_expect("R9 commit sets dirty", 12'h300, 32'h8000_7800);
        commit(2'b01, 10'h0);
        rd_expect("R5 zero-flag commit keeps", 12'h001, 32'h01);
        commit(2'b10, {5'h04, 5'h00});
        rd_expect("R5 accumulate", 12'h001, 32'h05);
        commit(2'b00, {5'h10, 5'h10});
        rd_expect("R6 invalid lane ignored", 12'h001, 32'h05);
    endtask

    task automatic t_multi;
        logic [31:0] v; logic il;
        req(OP_WR, 12'h001, 32'h0, v, il);
        rd_expect("R10 flags cleared", 12'h001, 32'h0);
        commit(2'b11, {5'h10, 5'h02});
        rd_expect("R6 two lanes", 12'h001, 32'h12);
    endtask

    task automatic t_collide;
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_WR; req_addr = 12'h001; req_wdata = 32'h08;
        commit_valid = 2'b10; commit_flags = {5'h01, 5'h00};
        @(posedge clk); #1;
        req_valid = 1'b0; req_op = OP_RD; req_wdata = '0;
        commit_valid = '0; commit_flags = '0;
        rd_expect("R7 write then or", 12'h001, 32'h09);
    endtask

    task automatic t_views;
        logic [31:0] v; logic il;
        req(OP_WR, 12'h003, 32'h0000_00FF, v, il);
        rd_expect("R8 flags view", 12'h001, 32'h1F);
        rd_expect("R8 rm view", 12'h002, 32'h07);
        req(OP_CLR, 12'h300, 32'h0000_6000, v, il);
        rd_expect("R9 fs cleared", 12'h300, 32'h0000_1800);
        req(OP_WR, 12'h002, 32'h0000_0002, v, il);
        rd_expect("R8 combined view", 12'h003, 32'h5F);
        rd_expect("R9 rm write sets dirty", 12'h300, 32'h8000_7800);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_mepc;
        t_setclear;
        t_unimpl;
        t_readonly;
        t_sd;
        t_sticky;
        t_multi;
        t_collide;
        t_views;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got running exp done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule